// File: doc/BRIEF.md
# Wormhole Output Port with Credit Flow Control

This block is the best-effort output side of one router port. Several source inputs compete for a single link toward a neighbouring router. Traffic arrives as packets. Each packet is a run of flits: the first flit carries the route chosen by the sender, and a separate end bit on each flit marks the final one. The port moves a packet across the link flit by flit. Once a source has won the port with a header, it keeps the port until its end-marked flit has gone. Flits of two different packets never mix on the link.

The neighbour's input buffer cannot refuse a flit, so the port keeps a credit count. After reset the count equals the number of flits that buffer holds. Every flit sent uses one credit. The neighbour returns one credit, as a one-cycle pulse, whenever a flit leaves its buffer. With no credit left, the port holds all ready signals low. The owning source then waits with its flit intact.

When no packet holds the port, sources are served in round-robin order. The search starts one place after the source that last finished a packet. Link outputs are registered, and a head flag marks the first flit of each packet on the link.

Top module: `wh_credit_port`

## Requirements
- R1: While reset is high and on the first cycle after it, `link_valid` is low. The credit count starts at DEPTH, and the round-robin search starts at source 0.
- R2: A flit is accepted when `src_valid[i]` and `src_ready[i]` are both high at a clock edge. One cycle later it appears on the link, with `link_valid` high for exactly that cycle and the same `link_flit` and `link_last`. With no acceptance, `link_valid` is low on the next cycle.
- R3: With no credit returned, at most DEPTH flits are accepted. After that, every `src_ready` bit stays low, and the waiting flit is sent later unchanged.
- R4: Each `link_credit` pulse allows exactly one more flit. A pulse in the same cycle as an acceptance leaves the count unchanged.
- R5: The credit count never exceeds DEPTH and never drops below zero. After every flit has been returned, exactly DEPTH flits can be sent again.
- R6: A packet starts when a flit is accepted with `src_last` low and the port is free. From then on, only that source can see `src_ready` high, until a flit with `src_last` high has been accepted from it. This holds even if the owning source drops `src_valid` partway through the packet.
- R7: When the port is free, `src_ready` goes to the first valid source at or after the search start, wrapping from N_SRC-1 back to 0. After a flit with `src_last` high is accepted from source k, the search start moves to k+1 (wrapping).
- R8: `link_head` is high with a link flit exactly when that flit was accepted while no packet held the port. This covers the first flit after reset and the first flit after a flit with `src_last` high. A single-flit packet has both head and last set.
- R9: No more than one `src_ready` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_SRC | Flit present on each source |
| src_flit | input | N_SRC*FLIT_W | Flit payload per source; source i is bits [i*FLIT_W +: FLIT_W] |
| src_last | input | N_SRC | Final-flit marker per source |
| src_ready | output | N_SRC | Port takes the source's flit at this edge |
| link_valid | output | 1 | Flit on the link this cycle |
| link_flit | output | FLIT_W | Flit payload toward the neighbour |
| link_last | output | 1 | Final-flit marker toward the neighbour |
| link_head | output | 1 | First flit of a packet |
| link_credit | input | 1 | One credit returned by the neighbour's buffer |

## Verification
The first pattern holds every source valid and returns no credits. This separates a correct stop at DEPTH flits from an off-by-one stall or overrun. The second pattern holds every source valid under steady credit return, which exposes the round-robin order and any move of the search start that happens at a header instead of at a tail. Random valid gaps inside packets, with random credit pulses, test whether ownership survives a silent owner and whether a send and a return landing in the same cycle are counted correctly. A run of single-flit packets shows whether a header that is also a tail wrongly locks the port. A refill run after full drain confirms the count comes back to exactly DEPTH.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;

  // Round-robin successor of an index in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Index width for a count of n, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic has_credit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= FULL;
    end else begin
      unique case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   if (cnt != FULL) cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign has_credit = (cnt != '0);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) take |-> cnt != '0);

  // R4
  cnt_same_chk: assert property (@(posedge clk) disable iff (rst)
    (take && give) |=> cnt == $past(cnt));

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !give) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/wh_owner_arb.sv
module wh_owner_arb
  import wh_port_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  input  logic             has_credit,
  input  logic             sel_last,
  output logic [N_SRC-1:0] sel_oh,
  output logic [N_SRC-1:0] grant,
  output logic             fire,
  output logic             busy
);
  localparam int IW = idx_bits(N_SRC);

  logic          locked;
  logic [IW-1:0] owner;
  logic [IW-1:0] ptr;
  logic [IW-1:0] pick_idx;
  logic          found;
  logic [IW-1:0] sel_idx;
  logic          sel_any;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!found && req[j]) begin
        found    = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  assign sel_idx = locked ? owner : pick_idx;
  assign sel_any = locked | found;
  assign sel_oh  = sel_any ? (N_SRC'(1) << sel_idx) : '0;
  assign grant   = has_credit ? sel_oh : '0;
  assign fire    = |(req & grant);
  assign busy    = locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (fire) begin
      if (sel_last) begin
        locked <= 1'b0;
        ptr    <= IW'(ring_next(int'(sel_idx), N_SRC));
      end else begin
        locked <= 1'b1;
        owner  <= sel_idx;
      end
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !sel_last) |=> (grant & ~$past(sel_oh)) == '0);

  // R7
  free_after_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && sel_last) |=> !locked);

endmodule

// File: rtl/wh_credit_port.sv
module wh_credit_port #(
  parameter int N_SRC  = 4,
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SRC-1:0]          src_valid,
  input  logic [N_SRC*FLIT_W-1:0]   src_flit,
  input  logic [N_SRC-1:0]          src_last,
  output logic [N_SRC-1:0]          src_ready,
  output logic                      link_valid,
  output logic [FLIT_W-1:0]         link_flit,
  output logic                      link_last,
  output logic                      link_head,
  input  logic                      link_credit
);
  logic [N_SRC-1:0]  sel_oh;
  logic [N_SRC-1:0]  grant;
  logic              fire;
  logic              busy;
  logic              has_credit;
  logic              sel_last;
  logic [FLIT_W-1:0] sel_flit;
  logic [FLIT_W-1:0] lane [N_SRC];

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_lane
      assign lane[g] = src_flit[g*FLIT_W +: FLIT_W];
    end
  endgenerate

  always_comb begin
    sel_flit = '0;
    sel_last = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      sel_flit = sel_flit | (lane[i] & {FLIT_W{sel_oh[i]}});
      sel_last = sel_last | (src_last[i] & sel_oh[i]);
    end
  end

  wh_owner_arb #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst(rst), .req(src_valid), .has_credit(has_credit),
    .sel_last(sel_last), .sel_oh(sel_oh), .grant(grant), .fire(fire), .busy(busy)
  );

  wh_credit_ctr #(.DEPTH(DEPTH)) u_crd (
    .clk(clk), .rst(rst), .take(fire), .give(link_credit), .has_credit(has_credit)
  );

  assign src_ready = grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_flit  <= '0;
      link_last  <= 1'b0;
      link_head  <= 1'b0;
    end else begin
      link_valid <= fire;
      if (fire) begin
        link_flit <= sel_flit;
        link_last <= sel_last;
        link_head <= !busy;
      end
    end
  end

  // R2
  link_follow_chk: assert property (@(posedge clk) disable iff (rst) fire |=> link_valid);

  // R2
  link_idle_chk: assert property (@(posedge clk) disable iff (rst) !fire |=> !link_valid);

  // R3
  stall_no_credit_chk: assert property (@(posedge clk) disable iff (rst)
    !has_credit |-> src_ready == '0);

endmodule

// File: tb/wh_credit_port_test.sv
`timescale 1ns/1ps
module wh_credit_port_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   src_valid = '0;
  logic [N*W-1:0] src_flit  = '0;
  logic [N-1:0]   src_last  = '0;
  logic [N-1:0]   src_ready;
  logic           link_valid, link_last, link_head;
  logic [W-1:0]   link_flit;
  logic           link_credit = 1'b0;

  always #2.5 clk = ~clk;

  wh_credit_port #(.N_SRC(N), .FLIT_W(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_flit(src_flit),
    .src_last(src_last), .src_ready(src_ready), .link_valid(link_valid),
    .link_flit(link_flit), .link_last(link_last), .link_head(link_head),
    .link_credit(link_credit)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] lf = 32'h1234_5679;
  int rem [N];
  int seq [N];
  int m_cred, m_owner, m_ptr, occ;
  bit m_locked;
  bit exp_v, exp_last, exp_head;
  logic [W-1:0] exp_flit;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  function automatic logic [W-1:0] flit_of(input int i);
    return W'(i * 4096 + (seq[i] % 4096));
  endfunction

  function automatic logic [N-1:0] model_ready(input logic [N-1:0] v);
    int sel = -1;
    if (m_locked) sel = m_owner;
    else
      for (int k = 0; k < N; k++) begin
        int j = (m_ptr + k) % N;
        if (sel < 0 && v[j]) sel = j;
      end
    return (m_cred > 0 && sel >= 0) ? (N'(1) << sel) : '0;
  endfunction

  task automatic drive_src(input logic [N-1:0] moved, input int rate, input int maxlen);
    for (int i = 0; i < N; i++) begin
      if (moved[i]) begin rem[i]--; seq[i]++; end
      if (rem[i] == 0) begin step_rnd(); rem[i] = 1 + int'(lf % 32'(maxlen)); end
      step_rnd();
      src_valid[i] = (int'(lf % 100) < rate);
      src_flit[i*W +: W] = flit_of(i);
      src_last[i] = (rem[i] == 1);
    end
  endtask

  task automatic run(input int cycles, input int rate, input int drain, input int maxlen,
                     output int acc);
    acc = 0;
    for (int c = 0; c < cycles; c++) begin
      logic [N-1:0] er, xf;
      @(negedge clk);
      chk(link_valid == exp_v, "R2 link_valid", link_valid, exp_v);
      if (exp_v) begin
        chk(link_flit == exp_flit && link_last == exp_last, "R2 link_flit/last",
            {link_last, link_flit}, {exp_last, exp_flit});
        chk(link_head == exp_head, "R8 link_head", link_head, exp_head);
        occ++;
      end
      er = model_ready(src_valid);
      chk(src_ready == er, "R3,R4,R6,R7,R9 src_ready", src_ready, er);
      xf = src_valid & er;
      exp_v = 1'b0;
      for (int i = 0; i < N; i++) if (xf[i]) begin
        exp_v = 1'b1; exp_flit = flit_of(i); exp_last = (rem[i] == 1);
        exp_head = !m_locked; acc++; m_cred--;
        if (rem[i] == 1) begin m_locked = 0; m_ptr = (i + 1) % N; end
        else begin m_locked = 1; m_owner = i; end
      end
      if (link_credit) m_cred++;
      @(posedge clk); #1;
      drive_src(xf, rate, maxlen);
      step_rnd();
      link_credit = (occ > 0) && (int'(lf % 100) < drain);
      if (link_credit) occ--;
    end
  endtask

  initial begin
    int acc;
    m_cred = D; m_locked = 0; m_owner = 0; m_ptr = 0; occ = 0; exp_v = 0;
    for (int i = 0; i < N; i++) begin rem[i] = 0; seq[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(link_valid == 1'b0, "R1 link_valid in reset", link_valid, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    drive_src('0, 100, 4);
    @(negedge clk);
    // R1: search starts at 0 with credits present
    chk(src_ready == 4'b0001 && link_valid == 1'b0, "R1 first grant",
        {link_valid, src_ready}, 1);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    // R3: no returns, all valid -> exactly D accepted
    run(20, 100, 0, 4, acc);
    chk(acc == D, "R3 accepted without credits", acc, D);
    // R7 saturation with steady returns
    run(300, 100, 80, 4, acc);
    // R4, R6 random gaps and pulses
    run(4000, 60, 50, 5, acc);
    // R8 single-flit packets
    run(600, 70, 60, 1, acc);
    // R5: drain fully, then refill with no returns
    run(60, 0, 100, 1, acc);
    chk(occ == 0, "R5 drained", occ, 0);
    run(20, 100, 0, 3, acc);
    chk(acc == D, "R5 refill count", acc, D);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule